// File: doc/BRIEF.md
# Pad Retention Status Flags with Per-Pin Access Filtering

This block holds one sticky flag for each pin of a 16-pin port. A flag is set when the chip enters its low-power standby state while retention is enabled for that pin. The flag records that the pad state of the pin is being held. Software reads the flags through a 32-bit register and clears them by writing zeros. Hardware can only set a flag, and only at the standby-entry event.

Every bus access is filtered bit by bit. A pin marked secure is hidden from non-secure accesses. Each security domain also has its own configuration bit that can shut out unprivileged accesses to the bits of that domain. A blocked bit reads as zero and ignores writes. No error, interrupt or bus fault is produced for a blocked access. The raw flag vector is also driven out for use by nearby logic.

The register interface is a plain single-cycle strobe interface: address hit, read and write. It has no valid/ready stream, so back-pressure does not apply.

Top module: `ioret_status_reg`

## Requirements
- R1: Flags live in bits 0–3 and 5–15 of the register. Bit 4 has no flag: it always reads 0 and is never set. Bits 31:16 always read 0.
- R2: After reset every flag is 0, so both the read data and the status vector are all zero.
- R3: On the clock edge where `stby_enter` is high, flag n becomes 1 if `ret_en[n]` is 1 on that edge.
- R4: On the edge where `bus_hit` and `bus_wr` are both high, each accessible bit that is written with 0 clears its flag.
- R5: Writing 1 to a flag bit leaves it unchanged. No flag rises without a `stby_enter` event.
- R6: When `pin_secure[n]` is 1 and `bus_secure` is 0, bit n reads 0 and a write leaves flag n unchanged.
- R7: When `bus_priv` is 0, bit n is blocked (it reads 0 and writes are ignored) if it is a secure bit and `priv_cfg_sec` is 1, or if it is a non-secure bit and `priv_cfg_nsec` is 1. This check is made separately for each bit.
- R8: If a standby-entry set and a software clear hit the same flag on the same edge, the flag ends up at 1.
- R9: `bus_rdata` is combinational from the current flags after masking, and it is zero unless `bus_hit` and `bus_rd` are both high. A write with `bus_hit` low changes nothing.
- R10: `ret_status` always shows the raw flags, whatever the security and privilege settings of the bus access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ret_en | input | 16 | Per-pin retention enable |
| stby_enter | input | 1 | Standby-entry pulse, one cycle wide |
| pin_secure | input | 16 | Per-pin secure attribute |
| priv_cfg_sec | input | 1 | Block unprivileged access to secure bits |
| priv_cfg_nsec | input | 1 | Block unprivileged access to non-secure bits |
| bus_hit | input | 1 | Register address selected |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_secure | input | 1 | Access is secure |
| bus_priv | input | 1 | Access is privileged |
| bus_rdata | output | 32 | Masked read data |
| ret_status | output | 16 | Raw flag vector |

## Verification
The bench writes all ones after setting every flag. A design that treats a write of 1 as a set, or that simply loads the write data, would change the flags there. It mixes secure and non-secure pins under non-secure and unprivileged accesses and swaps which privilege configuration bit is active. A design that applies the filter to the whole register, or that uses the wrong domain's privilege bit, would clear or show the wrong half of the flags. It also fires a standby-entry event and a clearing write on the same edge, where clear-priority logic would drop the flag. Finally it enables retention on bit 4 and strobes reads and writes with the address hit low, where a design would either grow a phantom flag or react to an unselected access.

// File: rtl/ioret_pkg.sv
`timescale 1ns/1ps
package ioret_pkg;
  localparam int unsigned PIN_COUNT = 16;
  localparam int unsigned REG_WIDTH = 32;
  localparam logic [PIN_COUNT-1:0] IMPL_DEFAULT = 16'hFFEF;

  typedef struct packed {
    logic secure;
    logic priv;
  } bus_attr_t;
endpackage

// File: rtl/ioret_access_filter.sv
`timescale 1ns/1ps
module ioret_access_filter
  import ioret_pkg::*;
#(
  parameter int unsigned NUM_PINS = PIN_COUNT
) (
  input  logic [NUM_PINS-1:0] pin_secure,
  input  logic                priv_cfg_sec,
  input  logic                priv_cfg_nsec,
  input  bus_attr_t           attr,
  output logic [NUM_PINS-1:0] allow
);
  for (genvar k = 0; k < NUM_PINS; k++) begin : g_bit
    logic sec_ok;
    logic priv_need;
    logic priv_ok;
    assign sec_ok    = attr.secure | ~pin_secure[k];
    assign priv_need = pin_secure[k] ? priv_cfg_sec : priv_cfg_nsec;
    assign priv_ok   = attr.priv | ~priv_need;
    assign allow[k]  = sec_ok & priv_ok;
  end
endmodule

// File: rtl/ioret_flag_bank.sv
`timescale 1ns/1ps
module ioret_flag_bank
  import ioret_pkg::*;
#(
  parameter int unsigned          NUM_PINS = PIN_COUNT,
  parameter logic [NUM_PINS-1:0]  IMPL     = IMPL_DEFAULT
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] set_req,
  input  logic [NUM_PINS-1:0] clr_req,
  output logic [NUM_PINS-1:0] flags
);
  for (genvar k = 0; k < NUM_PINS; k++) begin : g_flag
    if (IMPL[k]) begin : g_impl
      logic q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          q <= 1'b0;
        else if (set_req[k]) q <= 1'b1;
        else if (clr_req[k]) q <= 1'b0;
      end
      assign flags[k] = q;

      p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (set_req[k] && clr_req[k]) |=> flags[k]);
      p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req[k] && !set_req[k]) |=> !flags[k]);
      p_no_spont_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!flags[k] && !set_req[k]) |=> !flags[k]);
      p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[k] && !clr_req[k]) |=> flags[k]);
    end else begin : g_none
      logic unused_req;
      assign unused_req = set_req[k] ^ clr_req[k];
      assign flags[k]   = 1'b0;
    end
  end
endmodule

// File: rtl/ioret_read_mux.sv
`timescale 1ns/1ps
module ioret_read_mux
  import ioret_pkg::*;
#(
  parameter int unsigned NUM_PINS = PIN_COUNT,
  parameter int unsigned DATA_W   = REG_WIDTH
) (
  input  logic                rd_en,
  input  logic [NUM_PINS-1:0] flags,
  input  logic [NUM_PINS-1:0] allow,
  output logic [DATA_W-1:0]   rdata
);
  localparam int unsigned PAD_W = DATA_W - NUM_PINS;

  always_comb begin
    rdata = '0;
    if (rd_en) rdata = {{PAD_W{1'b0}}, flags & allow};
  end
endmodule

// File: rtl/ioret_status_reg.sv
`timescale 1ns/1ps
module ioret_status_reg
  import ioret_pkg::*;
#(
  parameter int unsigned          NUM_PINS = PIN_COUNT,
  parameter int unsigned          DATA_W   = REG_WIDTH,
  parameter logic [NUM_PINS-1:0]  IMPL     = IMPL_DEFAULT
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] ret_en,
  input  logic                stby_enter,
  input  logic [NUM_PINS-1:0] pin_secure,
  input  logic                priv_cfg_sec,
  input  logic                priv_cfg_nsec,
  input  logic                bus_hit,
  input  logic                bus_rd,
  input  logic                bus_wr,
  input  logic [DATA_W-1:0]   bus_wdata,
  input  logic                bus_secure,
  input  logic                bus_priv,
  output logic [DATA_W-1:0]   bus_rdata,
  output logic [NUM_PINS-1:0] ret_status
);
  bus_attr_t           attr;
  logic [NUM_PINS-1:0] allow;
  logic [NUM_PINS-1:0] set_req;
  logic [NUM_PINS-1:0] clr_req;
  logic                wr_en;
  logic                rd_en;
  logic                unused_wdata;

  assign attr.secure  = bus_secure;
  assign attr.priv    = bus_priv;
  assign wr_en        = bus_hit & bus_wr;
  assign rd_en        = bus_hit & bus_rd;
  assign unused_wdata = ^bus_wdata[DATA_W-1:NUM_PINS];
  assign set_req      = {NUM_PINS{stby_enter}} & ret_en;
  assign clr_req      = {NUM_PINS{wr_en}} & allow & ~bus_wdata[NUM_PINS-1:0];

  ioret_access_filter #(.NUM_PINS(NUM_PINS)) u_filter (
    .pin_secure   (pin_secure),
    .priv_cfg_sec (priv_cfg_sec),
    .priv_cfg_nsec(priv_cfg_nsec),
    .attr         (attr),
    .allow        (allow)
  );

  ioret_flag_bank #(.NUM_PINS(NUM_PINS), .IMPL(IMPL)) u_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_req(set_req),
    .clr_req(clr_req),
    .flags  (ret_status)
  );

  ioret_read_mux #(.NUM_PINS(NUM_PINS), .DATA_W(DATA_W)) u_rmux (
    .rd_en(rd_en),
    .flags(ret_status),
    .allow(allow),
    .rdata(bus_rdata)
  );

  for (genvar k = 0; k < NUM_PINS; k++) begin : g_chk
    if (IMPL[k]) begin : g_impl
      p_set_on_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (stby_enter && ret_en[k]) |=> ret_status[k]);
      p_blocked_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !allow[k] && !(stby_enter && ret_en[k])) |=> $stable(ret_status[k]));
    end else begin : g_none
      p_unimpl_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !ret_status[k]);
    end
  end

  always_comb begin
    if (rst_n) begin
      p_upper_zero_r1: assert (bus_rdata[DATA_W-1:NUM_PINS] == '0);
      for (int k = 0; k < NUM_PINS; k++) begin
        if (!allow[k] || !rd_en) begin
          p_rd_blocked_r6: assert (!bus_rdata[k]);
        end
      end
    end
  end
endmodule

// File: tb/ioret_status_reg_bench.sv
`timescale 1ns/1ps
module ioret_status_reg_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] ret_en = '0;
  logic        stby_enter = 1'b0;
  logic [15:0] pin_secure = '0;
  logic        priv_cfg_sec = 1'b0;
  logic        priv_cfg_nsec = 1'b0;
  logic        bus_hit = 1'b0;
  logic        bus_rd = 1'b0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_secure = 1'b0;
  logic        bus_priv = 1'b0;
  logic [31:0] bus_rdata;
  logic [15:0] ret_status;

  int total = 0;
  int bad = 0;
  bit mon_go = 1'b0;
  bit finished = 1'b0;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sb_q[$];

  always #4 clk = ~clk;

  ioret_status_reg u_ioret_status_reg (
    .clk(clk), .rst_n(rst_n), .ret_en(ret_en), .stby_enter(stby_enter),
    .pin_secure(pin_secure), .priv_cfg_sec(priv_cfg_sec),
    .priv_cfg_nsec(priv_cfg_nsec), .bus_hit(bus_hit), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_secure(bus_secure),
    .bus_priv(bus_priv), .bus_rdata(bus_rdata), .ret_status(ret_status)
  );

  // Monitor: pops expected read data and compares mid-cycle.
  always @(negedge clk) begin
    #2;
    if (mon_go) begin
      item_t it;
      if (sb_q.size() == 0) begin
        bad++; total++;
        $display("FAIL R9 unexpected sample actual=%h expected=none", bus_rdata);
      end else begin
        it = sb_q.pop_front();
        total++;
        if (bus_rdata !== it.exp) begin
          bad++;
          $display("FAIL %s rdata actual=%h expected=%h", it.tag, bus_rdata, it.exp);
        end
      end
    end
  end

  task automatic idle();
    @(negedge clk);
    bus_hit = 0; bus_rd = 0; bus_wr = 0; stby_enter = 0; mon_go = 0;
  endtask

  task automatic rd(input bit hit, input bit sec, input bit priv,
                    input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_hit = hit; bus_rd = 1; bus_wr = 0; bus_secure = sec; bus_priv = priv;
    sb_q.push_back('{exp: exp, tag: tag});
    mon_go = 1;
    idle();
  endtask

  task automatic wr(input bit hit, input bit sec, input bit priv, input logic [31:0] d);
    @(negedge clk);
    bus_hit = hit; bus_rd = 0; bus_wr = 1; bus_secure = sec; bus_priv = priv;
    bus_wdata = d;
    idle();
  endtask

  task automatic standby(input logic [15:0] en);
    @(negedge clk);
    ret_en = en; stby_enter = 1;
    idle();
  endtask

  task automatic chk_status(input logic [15:0] exp, input string tag);
    @(negedge clk);
    #2;
    total++;
    if (ret_status !== exp) begin
      bad++;
      $display("FAIL %s status actual=%h expected=%h", tag, ret_status, exp);
    end
  endtask

  initial begin
    #(8 * 20000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R2: reset state
    rd(1, 1, 1, 32'h0, "R2");
    chk_status(16'h0, "R2");
    // R3 / R1: standby with all enables; bit 4 stays empty
    standby(16'hFFFF);
    rd(1, 1, 1, 32'h0000_FFEF, "R1_R3");
    // R5: writing ones changes nothing
    wr(1, 1, 1, 32'hFFFF_FFFF);
    rd(1, 1, 1, 32'h0000_FFEF, "R5");
    // R4: clear bits 0 and 1
    wr(1, 1, 1, 32'hFFFF_FFFC);
    rd(1, 1, 1, 32'h0000_FFEC, "R4");
    // R6: non-secure access to secure pins 4..7
    pin_secure = 16'h00F0;
    rd(1, 0, 1, 32'h0000_FF0C, "R6");
    wr(1, 0, 1, 32'h0);
    rd(1, 1, 1, 32'h0000_00E0, "R6");
    // R7: secure-domain privilege blocking
    standby(16'hFFFF);
    priv_cfg_sec = 1; priv_cfg_nsec = 0;
    rd(1, 1, 0, 32'h0000_FF0F, "R7");
    wr(1, 1, 0, 32'h0);
    rd(1, 1, 1, 32'h0000_00E0, "R7");
    // R7: non-secure-domain privilege blocking
    priv_cfg_sec = 0; priv_cfg_nsec = 1;
    rd(1, 1, 0, 32'h0000_00E0, "R7");
    wr(1, 1, 0, 32'h0);
    chk_status(16'h0, "R7");
    priv_cfg_nsec = 0;
    // R8: set and clear on the same edge; R1: bit 4 enable ignored
    @(negedge clk);
    ret_en = 16'h0011; stby_enter = 1;
    bus_hit = 1; bus_wr = 1; bus_secure = 1; bus_priv = 1; bus_wdata = 32'h0;
    idle();
    rd(1, 1, 1, 32'h0000_0001, "R8");
    // R9: no read data without hit or rd; write with hit low ignored
    rd(0, 1, 1, 32'h0, "R9");
    @(negedge clk);
    bus_hit = 1; bus_rd = 0; bus_secure = 1; bus_priv = 1;
    sb_q.push_back('{exp: 32'h0, tag: "R9"});
    mon_go = 1;
    idle();
    wr(0, 1, 1, 32'h0);
    rd(1, 1, 1, 32'h0000_0001, "R9");
    // R10: raw status is unaffected by masking
    pin_secure = 16'hFFFF;
    rd(1, 0, 1, 32'h0, "R10");
    chk_status(16'h0001, "R10");
    repeat (2) @(negedge clk);
    total++;
    if (sb_q.size() != 0) begin
      bad++;
      $display("FAIL R9 queue actual=%0d expected=0", sb_q.size());
    end
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule